// File: doc/BRIEF.md
# Management Client Readiness Sequencer

This block follows a sideband thermal and management client from power-up to full service. It watches the power-good level, the platform reset level, a core-reset-done level and a fatal-error flag. From these it moves through four readiness phases: off, data-not-ready, partial service and full service. Each phase admits a different set of commands.

A command decoder upstream presents one decoded command per strobe. The strobe carries a command kind, an address-space tag that marks core register space, and a flag for an internal control fault. One clock later the sequencer returns a registered response pulse. The pulse carries a disposition: ignore, answer normally, answer with zero data, or return no data. It also carries the completion code the host should read. The data paths for registers and temperature sit outside the block and act on the disposition.

Top module: `mgmt_ready_seq`

## Requirements
- R1: The phase output encodes off as 0, data-not-ready as 1, partial as 2 and full as 3. It reads 0 after block reset and while power-good is low, and it falls to 0 on the edge after power-good drops, whatever the phase. A command taken in phase 0 gets disposition 0 (ignore) and completion code 0x00.
- R2: Phase 0 moves to phase 1 on the INIT_CYCLES-th consecutive clock edge that samples power-good high.
- R3: In phase 1, kinds 0 (ping) and 1 (discovery) get disposition 1 (normal) and code 0x40.
- R4: In phase 1 with no fatal error, kind 2 (temperature read) gets disposition 2 (zero data) and code 0x40.
- R5: In phase 1 with no fatal error, kinds 3 to 7 outside core space get disposition 3 (no data) and code 0x81.
- R6: Phase 1 moves to phase 2 on the RST_CYCLES-th consecutive edge that samples platform reset low. Platform reset high in phase 1, 2 or 3 returns the phase to 1 and restarts that count.
- R7: Phase 2 moves to phase 3 on an edge where core-reset-done is high. Phase 3 returns to phase 2 on an edge where it is low.
- R8: A command of kind 3 to 7 with the core-space tag set gets disposition 1 and code 0x40 only in phase 3. In phases 1 and 2 it gets disposition 3 and code 0x81, even under a fatal error.
- R9: With the fatal-error flag high in phase 1, every command outside core space, temperature read included, gets disposition 1 and code 0x40.
- R10: A command taken in phase 1, 2 or 3 with the control-fault flag high gets disposition 3 and code 0x91. This overrides every other rule.
- R11: The response valid output pulses exactly one cycle after each sampled strobe and is low otherwise. Disposition and code read 0 when valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| pwr_good | input | 1 | Power-good level, high when supply is valid |
| plat_rst | input | 1 | Platform reset level, high while asserted |
| core_done | input | 1 | High once the core has left reset |
| fatal_err | input | 1 | Fatal or catastrophic error flag |
| cmd_valid | input | 1 | Command strobe, one per clock at most |
| cmd_kind | input | 3 | 0 ping, 1 discovery, 2 temperature read, 3 to 7 register accesses |
| cmd_core | input | 1 | Address-space tag: 1 selects core register space |
| ctrl_fault | input | 1 | Internal control fault present for this command |
| phase | output | 2 | Readiness phase, registered |
| rsp_valid | output | 1 | Response pulse, one cycle after the strobe |
| rsp_disp | output | 2 | 0 ignore, 1 normal, 2 zero data, 3 no data |
| rsp_code | output | 8 | Completion code: 0x00, 0x40, 0x81 or 0x91 |

## Verification
The bench targets the exact edge on which each delay expires. A counter that is off by one would flip the phase a cycle early or late, and the model comparison catches it on that cycle. A platform-reset glitch part way through the reset delay must restart the count. A design that only pauses the count would reach partial service too soon. The bench also covers a fatal error during data-not-ready while core space is requested: a design that lets the fatal override open core space would answer normally where a timeout belongs. Control faults are sent in every phase, power is dropped in full service, and core-reset-done is toggled in both directions, so every priority between these rules is exercised.

// File: rtl/mrs_pkg.sv
package mrs_pkg;
  typedef enum logic [1:0] {
    PH_OFF  = 2'd0,
    PH_DNR  = 2'd1,
    PH_PART = 2'd2,
    PH_FULL = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    DSP_IGNORE = 2'd0,
    DSP_NORMAL = 2'd1,
    DSP_ZERO   = 2'd2,
    DSP_NODATA = 2'd3
  } disp_e;

  localparam int KIND_W = 3;
  localparam logic [KIND_W-1:0] K_PING         = 3'd0;
  localparam logic [KIND_W-1:0] K_DISCOVER     = 3'd1;
  localparam logic [KIND_W-1:0] K_TEMP         = 3'd2;
  localparam logic [KIND_W-1:0] K_FIRST_ACCESS = 3'd3;

  localparam logic [7:0] CC_NONE    = 8'h00;
  localparam logic [7:0] CC_OK      = 8'h40;
  localparam logic [7:0] CC_TIMEOUT = 8'h81;
  localparam logic [7:0] CC_FAULT   = 8'h91;
endpackage

// File: rtl/mrs_delay.sv
// Counts consecutive cycles with run high; done pulses on the LIMIT-th one.
module mrs_delay #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  output logic done
);
  localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  assign done = run && !clear && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt <= '0;
    end else if (run) begin
      cnt <= done ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mrs_phase_fsm.sv
module mrs_phase_fsm
  import mrs_pkg::*;
#(
  parameter int INIT_CYCLES = 20000,
  parameter int RST_CYCLES  = 100000
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   pwr_good,
  input  logic   plat_rst,
  input  logic   core_done,
  output phase_e phase
);
  phase_e phase_nx;
  logic   init_run, init_clr, init_done;
  logic   hold_run, hold_clr, hold_done;

  assign init_run = pwr_good && (phase == PH_OFF);
  assign init_clr = !init_run;
  assign hold_run = pwr_good && !plat_rst && (phase == PH_DNR);
  assign hold_clr = !hold_run;

  mrs_delay #(.LIMIT(INIT_CYCLES)) u_init_dly (
    .clk(clk), .rst(rst), .clear(init_clr), .run(init_run), .done(init_done)
  );

  mrs_delay #(.LIMIT(RST_CYCLES)) u_hold_dly (
    .clk(clk), .rst(rst), .clear(hold_clr), .run(hold_run), .done(hold_done)
  );

  always_comb begin
    phase_nx = phase;
    if (!pwr_good) begin
      phase_nx = PH_OFF;
    end else if (phase == PH_OFF) begin
      if (init_done) phase_nx = PH_DNR;
    end else if (plat_rst) begin
      phase_nx = PH_DNR;
    end else begin
      case (phase)
        PH_DNR:  if (hold_done) phase_nx = PH_PART;
        PH_PART: if (core_done) phase_nx = PH_FULL;
        PH_FULL: if (!core_done) phase_nx = PH_PART;
        default: phase_nx = PH_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_OFF;
    else     phase <= phase_nx;
  end

  assert_off_when_unpowered_R1: assert property (@(posedge clk) disable iff (rst)
    !pwr_good |=> phase == PH_OFF);

  assert_off_leaves_to_dnr_R2: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_OFF) |=> (phase == PH_OFF || phase == PH_DNR));

  assert_reset_back_to_dnr_R6: assert property (@(posedge clk) disable iff (rst)
    (pwr_good && plat_rst && phase != PH_OFF) |=> phase == PH_DNR);

  assert_full_needs_core_R7: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_PART && !core_done) |=> phase != PH_FULL);
endmodule

// File: rtl/mrs_dispatch.sv
module mrs_dispatch
  import mrs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  phase_e            phase,
  input  logic              fatal_err,
  input  logic              cmd_valid,
  input  logic [KIND_W-1:0] cmd_kind,
  input  logic              cmd_core,
  input  logic              ctrl_fault,
  output logic              rsp_valid,
  output disp_e             rsp_disp,
  output logic [7:0]        rsp_code
);
  disp_e      d_disp;
  logic [7:0] d_code;
  logic       is_access, core_hit, relaxed;

  assign is_access = (cmd_kind >= K_FIRST_ACCESS);
  assign core_hit  = is_access && cmd_core;
  assign relaxed   = (phase != PH_DNR) || fatal_err;

  always_comb begin
    d_disp = DSP_IGNORE;
    d_code = CC_NONE;
    if (phase == PH_OFF) begin
      d_disp = DSP_IGNORE;
      d_code = CC_NONE;
    end else if (ctrl_fault) begin
      d_disp = DSP_NODATA;
      d_code = CC_FAULT;
    end else if (core_hit) begin
      d_disp = (phase == PH_FULL) ? DSP_NORMAL : DSP_NODATA;
      d_code = (phase == PH_FULL) ? CC_OK : CC_TIMEOUT;
    end else if (cmd_kind == K_PING || cmd_kind == K_DISCOVER) begin
      d_disp = DSP_NORMAL;
      d_code = CC_OK;
    end else if (cmd_kind == K_TEMP) begin
      d_disp = relaxed ? DSP_NORMAL : DSP_ZERO;
      d_code = CC_OK;
    end else begin
      d_disp = relaxed ? DSP_NORMAL : DSP_NODATA;
      d_code = relaxed ? CC_OK : CC_TIMEOUT;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_disp  <= DSP_IGNORE;
      rsp_code  <= CC_NONE;
    end else begin
      rsp_valid <= cmd_valid;
      rsp_disp  <= cmd_valid ? d_disp : DSP_IGNORE;
      rsp_code  <= cmd_valid ? d_code : CC_NONE;
    end
  end

  assert_resp_follows_strobe_R11: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> rsp_valid);

  assert_no_spurious_resp_R11: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> !rsp_valid);

  assert_core_gated_R8: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_core && is_access && !ctrl_fault &&
     (phase == PH_DNR || phase == PH_PART)) |=> rsp_code == CC_TIMEOUT);

  assert_fault_code_R10: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && ctrl_fault && phase != PH_OFF) |=> rsp_code == CC_FAULT);

  assert_off_ignored_R1: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && phase == PH_OFF) |=> (rsp_disp == DSP_IGNORE && rsp_code == CC_NONE));
endmodule

// File: rtl/mgmt_ready_seq.sv
module mgmt_ready_seq
  import mrs_pkg::*;
#(
  parameter int INIT_CYCLES = 20000,
  parameter int RST_CYCLES  = 100000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pwr_good,
  input  logic       plat_rst,
  input  logic       core_done,
  input  logic       fatal_err,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_kind,
  input  logic       cmd_core,
  input  logic       ctrl_fault,
  output logic [1:0] phase,
  output logic       rsp_valid,
  output logic [1:0] rsp_disp,
  output logic [7:0] rsp_code
);
  phase_e ph;
  disp_e  disp;

  mrs_phase_fsm #(.INIT_CYCLES(INIT_CYCLES), .RST_CYCLES(RST_CYCLES)) u_fsm (
    .clk(clk), .rst(rst), .pwr_good(pwr_good), .plat_rst(plat_rst),
    .core_done(core_done), .phase(ph)
  );

  mrs_dispatch u_disp (
    .clk(clk), .rst(rst), .phase(ph), .fatal_err(fatal_err),
    .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_core(cmd_core),
    .ctrl_fault(ctrl_fault), .rsp_valid(rsp_valid), .rsp_disp(disp),
    .rsp_code(rsp_code)
  );

  assign phase    = ph;
  assign rsp_disp = disp;
endmodule

// File: tb/mgmt_ready_seq_bench.sv
`timescale 1ns/1ps
module mgmt_ready_seq_bench;
  localparam int INIT = 8;
  localparam int HOLD = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pg = 0, srst = 1, cdone = 0, fat = 0, cv = 0, space = 0, fault = 0;
  logic [2:0] kind = 0;
  logic [1:0] phase, disp;
  logic       rv;
  logic [7:0] code;

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  mgmt_ready_seq #(.INIT_CYCLES(INIT), .RST_CYCLES(HOLD)) u_mgmt_ready_seq (
    .clk(clk), .rst(rst), .pwr_good(pg), .plat_rst(srst), .core_done(cdone),
    .fatal_err(fat), .cmd_valid(cv), .cmd_kind(kind), .cmd_core(space),
    .ctrl_fault(fault), .phase(phase), .rsp_valid(rv), .rsp_disp(disp),
    .rsp_code(code)
  );

  // Behavioural reference: phase, run-length counters, expected response.
  int mp = 0, pg_run = 0, lo_run = 0;
  int ev = 0, ed = 0, ec = 0;
  string etag = "R11";

  function automatic string pick_tag(int p, bit f, bit ft, int k, bit sp);
    if (p == 0) return "R1";
    if (f) return "R10";
    if (k >= 3 && sp) return "R8";
    if (p == 1 && ft) return "R9";
    if (p == 1 && k <= 1) return "R3";
    if (p == 1 && k == 2) return "R4";
    if (p == 1) return "R5";
    return "R11";
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mp = 0; pg_run = 0; lo_run = 0; ev = 0; ed = 0; ec = 0;
    end else begin
      ev = cv; ed = 0; ec = 0;
      if (cv) begin
        etag = pick_tag(mp, fault, fat, kind, space);
        if (mp == 0) begin ed = 0; ec = 0; end
        else if (fault) begin ed = 3; ec = 'h91; end
        else if (kind >= 3 && space) begin
          if (mp == 3) begin ed = 1; ec = 'h40; end else begin ed = 3; ec = 'h81; end
        end else if (mp == 1 && !fat && kind == 2) begin ed = 2; ec = 'h40; end
        else if (mp == 1 && !fat && kind >= 3) begin ed = 3; ec = 'h81; end
        else begin ed = 1; ec = 'h40; end
      end else etag = "R11";
      if (!pg) begin
        mp = 0; pg_run = 0; lo_run = 0;
      end else if (mp == 0) begin
        pg_run++;
        if (pg_run == INIT) begin mp = 1; pg_run = 0; lo_run = 0; end
      end else if (srst) begin
        mp = 1; lo_run = 0;
      end else if (mp == 1) begin
        lo_run++;
        if (lo_run == HOLD) begin mp = 2; lo_run = 0; end
      end else if (mp == 2) begin
        if (cdone) mp = 3;
      end else if (!cdone) mp = 2;
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", tag, what, act, exp, cyc);
    end
  endtask

  function automatic string phase_tag(int p);
    if (p == 0) return "R1";
    if (p == 1) return "R2";
    if (p == 2) return "R6";
    return "R7";
  endfunction

  // Per-cycle comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk(phase_tag(mp), "phase", phase, mp);
      chk("R11", "valid", rv, ev);
      chk(etag, "disp", disp, ed);
      chk(etag, "code", code, ec);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Drive one command, then check its response on the next negedge.
  task automatic cmd(int k, bit sp, int xd, int xc, string tag);
    @(negedge clk);
    cv = 1; kind = 3'(k); space = sp;
    @(negedge clk);
    cv = 0;
    chk(tag, "directed disp", disp, xd);
    chk(tag, "directed code", code, xc);
  endtask

  initial begin
    idle(3);
    chk("R1", "reset phase", phase, 0);
    chk("R11", "reset valid", rv, 0);
    rst = 0;
    cmd(0, 0, 0, 'h00, "R1");
    cmd(4, 1, 0, 'h00, "R1");
    @(negedge clk); pg = 1;
    idle(INIT - 1);
    chk("R2", "not yet dnr", phase, 0);
    idle(1);
    chk("R2", "dnr reached", phase, 1);
    cmd(0, 0, 1, 'h40, "R3");
    cmd(1, 1, 1, 'h40, "R3");
    cmd(2, 0, 2, 'h40, "R4");
    cmd(3, 0, 3, 'h81, "R5");
    cmd(7, 0, 3, 'h81, "R5");
    cmd(5, 1, 3, 'h81, "R8");
    fat = 1;
    cmd(2, 0, 1, 'h40, "R9");
    cmd(4, 0, 1, 'h40, "R9");
    cmd(4, 1, 3, 'h81, "R8");
    fat = 0; fault = 1;
    cmd(0, 0, 3, 'h91, "R10");
    fault = 0;
    @(negedge clk); srst = 0;
    idle(5);
    srst = 1; idle(1); srst = 0;
    idle(HOLD - 1);
    chk("R6", "hold not expired", phase, 1);
    idle(1);
    chk("R6", "partial reached", phase, 2);
    cmd(3, 1, 3, 'h81, "R8");
    cmd(2, 0, 1, 'h40, "R6");
    cdone = 1; idle(1);
    chk("R7", "full reached", phase, 3);
    cmd(6, 1, 1, 'h40, "R8");
    fault = 1; cmd(6, 1, 3, 'h91, "R10"); fault = 0;
    cdone = 0; idle(1);
    chk("R7", "back to partial", phase, 2);
    cdone = 1; idle(1);
    srst = 1; idle(1);
    chk("R6", "reset returns dnr", phase, 1);
    srst = 0; idle(HOLD + 2);
    chk("R7", "full again", phase, 3);
    pg = 0; idle(1);
    chk("R1", "power drop", phase, 0);
    cmd(0, 0, 0, 'h00, "R1");
    pg = 1;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      cv = $urandom_range(0, 1);
      kind = 3'($urandom_range(0, 7));
      space = $urandom_range(0, 1);
      fault = ($urandom_range(0, 15) == 0);
      fat = ($urandom_range(0, 7) == 0);
      if ($urandom_range(0, 31) == 0) cdone = ~cdone;
      if ($urandom_range(0, 59) == 0) srst = ~srst;
      if ($urandom_range(0, 299) == 0) pg = ~pg;
    end
    @(negedge clk); cv = 0;
    idle(2);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule